// File: doc/BRIEF.md
# Control-Plane Pixel Source Selector

This block builds one 32-bit display pixel per accepted input beat. Each beat carries three words read in parallel from a frame store: an 8-bit indexed value, a 32-bit direct-colour word and a 32-bit control-plane word. The top byte of the control word is a per-pixel tag. One tag value picks the direct-colour word. Every other value picks a colour-table lookup addressed by the indexed value.

The colour table sits outside the block. The block drives a lookup request in the cycle it accepts a beat. The table answers with a 24-bit red/green/blue triple one cycle later. The block holds that answer if the pipeline is stalled. The finished pixel leaves on a valid/ready stream two cycles after acceptance. It is packed red-high or blue-high under a configuration input, and its top byte is zero. Scan timing and frame-store fetch are done upstream (lines are 1024 pixels, visible area at most 1024 by 768).

Top module: `pxsel_top`

## Requirements
- R1: When bits [31:24] of `in_ctrl` equal 8'h03, the pixel takes its colour from `in_direct`, with red in bits [7:0], green in bits [15:8] and blue in bits [23:16].
- R2: For any other tag value, including 8'h03 in a lower byte of the control word, the pixel takes its colour from the colour-table answer for `in_index`. The answer holds red in [23:16], green in [15:8] and blue in [7:0].
- R3: Bits [31:24] of `in_direct` never affect the output. `in_index` does not affect a pixel whose colour is taken from the direct word.
- R4: With `cfg_bgr` = 0 the output is {8'h00, red, green, blue}. With `cfg_bgr` = 1 it is {8'h00, blue, green, red}.
- R5: Bits [31:24] of `out_pixel` are zero whenever `out_valid` is high.
- R6: With `out_ready` held high, a beat accepted at clock edge N appears on the output from edge N+2, and pixels leave in acceptance order.
- R7: While `out_valid` is high and `out_ready` is low, the output pixel holds steady. No pixel is dropped or duplicated. At most two pixels are in flight.
- R8: `pal_req_valid` is high, with `pal_req_addr` = `in_index`, in exactly the cycles in which a beat is accepted. The answer on `pal_rsp_data` is used one cycle later, even if the pipeline stalls after that.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_bgr | input | 1 | 1 = blue in the high channel of the output |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_index | input | 8 | Indexed-plane value |
| in_direct | input | 32 | Direct-colour word |
| in_ctrl | input | 32 | Control-plane word, tag in [31:24] |
| pal_req_valid | output | 1 | Colour-table lookup request |
| pal_req_addr | output | 8 | Colour-table address |
| pal_rsp_data | input | 24 | Colour-table answer, one cycle after request |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts pixel |
| out_pixel | output | 32 | Packed output pixel |

## Verification
The risky overlap is a new colour-table answer arriving in the same cycle that the output stage is stalled. The first stage must keep that answer while it also holds its own beat. The bench provokes this by streaming mixed direct and looked-up beats while toggling `out_ready` in an irregular pattern. Its table model drives junk on `pal_rsp_data` in every cycle with no request. A pixel built from a lost answer shows up as a mismatch against the expected stream, and the per-cycle hold check catches any change while stalled.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;
  localparam int CH_W  = 8;
  localparam int PIX_W = 32;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // tag sits in the top byte of the control word
  function automatic logic tag_is_direct(input logic [31:0] ctrl, input logic [7:0] tag);
    return ctrl[31:24] == tag;
  endfunction

  // direct word: [23:16] blue, [15:8] green, [7:0] red, top byte unused
  function automatic rgb_t direct_to_rgb(input logic [31:0] w);
    rgb_t c;
    c.r = w[7:0];
    c.g = w[15:8];
    c.b = w[23:16];
    return c;
  endfunction

  function automatic logic [PIX_W-1:0] pack_pixel(input rgb_t c, input logic bgr);
    if (bgr) return {8'h00, c.b, c.g, c.r};
    return {8'h00, c.r, c.g, c.b};
  endfunction
endpackage

// File: rtl/pxsel_stage_in.sv
module pxsel_stage_in
  import pxsel_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  input  logic [31:0]      in_direct,
  input  logic [31:0]      in_ctrl,
  input  logic             down_room,
  output logic             s1_valid,
  output logic [31:0]      s1_direct,
  output logic [31:0]      s1_ctrl,
  output rgb_t             s1_pal,
  output logic             pal_req_valid,
  output logic [IDX_W-1:0] pal_req_addr,
  input  logic [23:0]      pal_rsp_data
);
  logic accept;
  logic rsp_fresh;
  rgb_t rsp_hold;

  assign in_ready      = !s1_valid || down_room;
  assign accept        = in_valid && in_ready;
  assign pal_req_valid = accept;
  assign pal_req_addr  = in_index;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_direct <= '0;
      s1_ctrl   <= '0;
      rsp_fresh <= 1'b0;
      rsp_hold  <= '0;
    end else begin
      rsp_fresh <= accept;
      if (rsp_fresh) rsp_hold <= rgb_t'(pal_rsp_data);
      if (in_ready) begin
        s1_valid <= in_valid;
        if (in_valid) begin
          s1_direct <= in_direct;
          s1_ctrl   <= in_ctrl;
        end
      end
    end
  end

  // the answer is live only in the cycle after the request
  assign s1_pal = rsp_fresh ? rgb_t'(pal_rsp_data) : rsp_hold;
endmodule

// File: rtl/pxsel_form.sv
module pxsel_form
  import pxsel_pkg::*;
#(
  parameter logic [7:0] TAG_DIRECT = 8'h03
) (
  input  logic [31:0]      ctrl,
  input  logic [31:0]      direct,
  input  rgb_t             pal,
  input  logic             bgr,
  output logic             is_direct,
  output logic [PIX_W-1:0] pixel
);
  rgb_t chosen;
  always_comb begin
    is_direct = tag_is_direct(ctrl, TAG_DIRECT);
    chosen    = is_direct ? direct_to_rgb(direct) : pal;
    pixel     = pack_pixel(chosen, bgr);
  end
endmodule

// File: rtl/pxsel_stage_out.sv
module pxsel_stage_out
  import pxsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic [PIX_W-1:0] pixel_in,
  output logic             room,
  output logic             take,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pixel
);
  assign room = !out_valid || out_ready;
  assign take = s1_valid && room;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else if (room) begin
      out_valid <= s1_valid;
      if (s1_valid) out_pixel <= pixel_in;
    end
  end
endmodule

// File: rtl/pxsel_top.sv
module pxsel_top
  import pxsel_pkg::*;
#(
  parameter int         IDX_W      = 8,
  parameter logic [7:0] TAG_DIRECT = 8'h03
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_bgr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  input  logic [31:0]      in_direct,
  input  logic [31:0]      in_ctrl,
  output logic             pal_req_valid,
  output logic [IDX_W-1:0] pal_req_addr,
  input  logic [23:0]      pal_rsp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_pixel
);
  logic             s1_valid;
  logic [31:0]      s1_direct;
  logic [31:0]      s1_ctrl;
  rgb_t             s1_pal;
  logic             s1_is_direct;
  logic [PIX_W-1:0] s1_pixel;
  logic             s2_room;
  logic             s1_take;
  logic             accept;

  assign accept = in_valid && in_ready;

  pxsel_stage_in #(.IDX_W(IDX_W)) u_in (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
    .down_room(s2_room),
    .s1_valid(s1_valid), .s1_direct(s1_direct), .s1_ctrl(s1_ctrl), .s1_pal(s1_pal),
    .pal_req_valid(pal_req_valid), .pal_req_addr(pal_req_addr),
    .pal_rsp_data(pal_rsp_data)
  );

  pxsel_form #(.TAG_DIRECT(TAG_DIRECT)) u_form (
    .ctrl(s1_ctrl), .direct(s1_direct), .pal(s1_pal), .bgr(cfg_bgr),
    .is_direct(s1_is_direct), .pixel(s1_pixel)
  );

  pxsel_stage_out u_out (
    .clk(clk), .rst(rst),
    .s1_valid(s1_valid), .pixel_in(s1_pixel),
    .room(s2_room), .take(s1_take),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );
endmodule

// File: rtl/pxsel_chk.sv
module pxsel_chk (
  input logic        clk,
  input logic        rst,
  input logic        cfg_bgr,
  input logic        accept,
  input logic        pal_req_valid,
  input logic        s1_valid,
  input logic        s1_take,
  input logic        s1_is_direct,
  input logic [31:0] s1_direct,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_pixel
);
  logic [2:0] occ;
  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else occ <= occ + 3'(accept) - 3'(out_valid && out_ready);
  end

  a_r1_direct_map: assert property (@(posedge clk) disable iff (rst)
    (s1_take && s1_is_direct && !cfg_bgr) |=>
      out_pixel == {8'h00, $past(s1_direct[7:0]), $past(s1_direct[15:8]), $past(s1_direct[23:16])});

  a_r5_top_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_pixel[31:24] == 8'h00);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));

  a_r7_occupancy: assert property (@(posedge clk) disable iff (rst)
    occ <= 3'd2);

  a_r8_req_fills: assert property (@(posedge clk) disable iff (rst)
    pal_req_valid |=> s1_valid);

  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind pxsel_top pxsel_chk u_chk (
  .clk(clk), .rst(rst), .cfg_bgr(cfg_bgr), .accept(accept),
  .pal_req_valid(pal_req_valid), .s1_valid(s1_valid), .s1_take(s1_take),
  .s1_is_direct(s1_is_direct), .s1_direct(s1_direct),
  .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
);

// File: tb/test_pxsel_top.sv
`timescale 1ns/1ps
module test_pxsel_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_bgr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_index = '0;
  logic [31:0] in_direct = '0;
  logic [31:0] in_ctrl = '0;
  logic        pal_req_valid;
  logic [7:0]  pal_req_addr;
  logic [23:0] pal_rsp_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pixel;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0, stall_mode = 0, lat_mode = 0;
  int wr = 0, rd = 0;
  logic [31:0] q_pix [0:255];
  int          q_cyc [0:255];
  bit          q_dir [0:255];
  bit          prev_stall = 0;
  logic [31:0] prev_pix = '0;

  always #5 clk = ~clk;

  pxsel_top i_pxsel_top (
    .clk(clk), .rst(rst), .cfg_bgr(cfg_bgr),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
    .pal_req_valid(pal_req_valid), .pal_req_addr(pal_req_addr),
    .pal_rsp_data(pal_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  function automatic logic [23:0] palf(input logic [7:0] a);
    return {a ^ 8'h3C, a + 8'd29, ~a};
  endfunction

  // colour table model: answers one cycle after a request, junk otherwise
  always @(posedge clk) begin
    cyc <= cyc + 1;
    pal_rsp_data <= pal_req_valid ? palf(pal_req_addr) : 24'h5A5A5A;
  end

  function automatic logic [31:0] expect_px(input logic [31:0] c, input logic [31:0] d,
                                            input logic [7:0] i, input logic bgr);
    logic [7:0] r, g, b;
    logic [23:0] p;
    if (c[31:24] == 8'h03) begin
      r = d[7:0]; g = d[15:8]; b = d[23:16];
    end else begin
      p = palf(i); r = p[23:16]; g = p[15:8]; b = p[7:0];
    end
    return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] c, input logic [31:0] d, input logic [7:0] i);
    @(negedge clk);
    in_valid = 1'b1; in_ctrl = c; in_direct = d; in_index = i;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    // R8: request issued in the accepting cycle with the index as address
    check(pal_req_valid && pal_req_addr == i, "R8 request", {23'h0, pal_req_valid, pal_req_addr}, {23'h0, 1'b1, i});
    q_pix[wr] = expect_px(c, d, i, cfg_bgr);
    q_cyc[wr] = cyc;
    q_dir[wr] = (c[31:24] == 8'h03);
    wr++;
    @(posedge clk);
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // output monitor
  always @(negedge clk) begin
    #2;
    if (!rst && !done) begin
      if (prev_stall)
        check(out_valid && out_pixel == prev_pix, "R7 hold while stalled", out_pixel, prev_pix);
      if (out_valid && out_ready) begin
        if (rd >= wr) check(1'b0, "R7 extra pixel", out_pixel, 32'h0);
        else begin
          check(out_pixel == q_pix[rd], q_dir[rd] ? "R1 R3 R4 R5 direct pixel" : "R2 R4 R5 table pixel",
                out_pixel, q_pix[rd]);
          if (lat_mode)
            check(cyc - q_cyc[rd] == 2, "R6 latency", 32'(cyc - q_cyc[rd]), 32'd2);
          rd++;
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_pix   = out_pixel;
    end
  end

  // sink pattern
  initial begin
    int sc = 0;
    forever begin
      @(negedge clk);
      sc++;
      out_ready = stall_mode ? !((sc % 4) == 1 || (sc % 7) == 3 || (sc % 11) == 5) : 1'b1;
    end
  end

  localparam logic [71:0] VEC [8] = '{
    {32'h0300_0000, 32'h0011_2233, 8'h10},  // direct
    {32'h03FF_FFFF, 32'hFFA0_B0C0, 8'hFF},  // direct, top byte set (R3)
    {32'h0200_0000, 32'h00AB_CDEF, 8'h00},  // table
    {32'h0400_0000, 32'h1234_5678, 8'h80},  // table
    {32'hFF00_0000, 32'h0000_0000, 8'hFF},  // table
    {32'h8300_0000, 32'h0102_0304, 8'h7E},  // table, high bit set
    {32'h0003_0000, 32'h0F0E_0D0C, 8'h01},  // table, tag value in wrong byte
    {32'h0300_0000, 32'h7F00_0000, 8'h44}   // direct black, top byte ignored
  };

  task automatic drain();
    int n = 0;
    idle_in();
    while (rd < wr && n < 200) begin @(negedge clk); n++; end
    check(rd == wr, "R7 all pixels delivered", 32'(rd), 32'(wr));
  endtask

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R9 out_valid in reset", {31'h0, out_valid}, 32'h0);
    check(in_ready, "R9 in_ready in reset", {31'h0, in_ready}, 32'h1);
    rst = 1'b0;
    @(negedge clk); #1;
    check(!out_valid && in_ready, "R9 idle after reset", {30'h0, out_valid, in_ready}, 32'h1);

    // table walk, both packings, full throughput, latency checked (R1 R2 R3 R4 R6)
    lat_mode = 1;
    for (int pass = 0; pass < 2; pass++) begin
      cfg_bgr = pass[0];
      for (int k = 0; k < 8; k++) send(VEC[k][71:40], VEC[k][39:8], VEC[k][7:0]);
      drain();
    end
    lat_mode = 0;

    // R3: same direct colour, different top byte and index, identical output
    cfg_bgr = 1'b0;
    send(32'h0300_0000, 32'h00C0_FFEE, 8'h01);
    send(32'h0300_0000, 32'hEEC0_FFEE, 8'hFE);
    drain();

    // R7 R8: irregular backpressure, mixed sources, gaps on input
    stall_mode = 1;
    for (int k = 0; k < 48; k++) begin
      send((k % 3 == 0) ? 32'h0300_0000 : {8'(k), 24'h0}, {8'(k * 5), 8'(k * 3), 8'(k), 8'(~k)}, 8'(k * 37));
      if (k % 9 == 4) idle_in();
    end
    drain();
    stall_mode = 0;

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule